// File: doc/BRIEF.md
# I2C Serial Memory Target Engine

This block is the bus-facing side of a 2K x 8 serial memory. It oversamples the two-wire bus (SCL, SDA) with a fast system clock and recognises START and STOP. It takes in a control byte and compares it with three chip-select straps. The control byte's block bits and the following word-address byte load an 11-bit address pointer. Data bytes are then either handed to a page buffer one at a time, or fetched from the memory array and shifted out.

SDA is driven through an open-drain enable: a high `sda_oe` pulls the line low. A busy input from the write-cycle logic makes the engine ignore every byte it is sent, and it gives no acknowledge. The master polls for the end of a write cycle by watching for that missing acknowledge. Reads come in three kinds: from the current pointer, from a freshly loaded pointer after a repeated START, and as a run of sequential bytes for as long as the master keeps acknowledging.

Top module: `i2c_mem_target`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts control-byte reception from its first bit at any point in a byte. A rising SDA while SCL is high (STOP) ends the command and releases SDA.
- R2: The control byte is sent MSB first. Its bits [7:4] must equal {1, strap[2], ~strap[1], strap[0]}, and the target then pulls SDA low for the ninth clock. On a mismatch it stays silent until the next START.
- R3: While `busy` is high, no byte is acknowledged (control, address or data) and no write is issued.
- R4: In a write command, control bits [3:1] become address bits [10:8] and the next byte becomes bits [7:0].
- R5: Every acknowledged data byte gives a one-cycle `wr_en` with its address and value. The low 4 address bits then count up and wrap inside the 16-byte page, and the upper 7 bits stay as they were.
- R6: A STOP that follows at least one written data byte pulses `wr_commit` for one cycle. A command with no data byte produces no pulse.
- R7: A repeated START after the word-address byte keeps the loaded pointer, and the read that follows returns the byte at that address.
- R8: A read with no address phase returns the byte at the last accessed address plus one. This holds after both reads and writes.
- R9: A master ACK after a read byte makes the target send the next byte. The pointer wraps from 0x7FF to 0x000.
- R10: After a master NACK the target keeps SDA released for every further clock until the next START.
- R11: `sda_oe` is low after reset, and it is only ever raised while the synchronized SCL is low. A 0 bit is driven as `sda_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Chip-select strap levels |
| busy | input | 1 | Internal write cycle in progress |
| rd_addr | output | 11 | Read address to array (data one cycle later) |
| rd_data | input | 8 | Array read data |
| wr_en | output | 1 | Byte write strobe to page buffer |
| wr_addr | output | 11 | Byte write address |
| wr_data | output | 8 | Byte write value |
| wr_commit | output | 1 | Start of internal write cycle after STOP |

## Verification
The bench builds the block with its defaults: an 11-bit address and a 16-byte page (PAGE_W = 4). With these values the top-address wrap from 0x7FF to 0x000 can be reached by a three-byte sequential read. The in-page wrap can be reached by a four-byte page write that starts two bytes below a page boundary. Random write-then-readback commands at random addresses and lengths combine both wraps with the block bits.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  localparam int BLK_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] PMASK = ADDR_W'((1 << PAGE_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WRITE, S_READ} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_p[1];
  assign scl_d = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_d = sda_p[2];

  logic start, stop, scl_rise, scl_fall;
  assign start    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop     = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  st_t st;
  logic [3:0] bitcnt;
  logic [7:0] sr, tx;
  logic [ADDR_W-1:0] ptr;
  logic [BLK_W-1:0] blk;
  logic mack, wrote;
  logic match;

  assign match   = sr[7:4] == {1'b1, strap[2], ~strap[1], strap[0]};
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sr <= '0; tx <= '0; ptr <= '0; blk <= '0;
      mack <= 1'b0; wrote <= 1'b0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      wr_commit <= 1'b0;
      if (start) begin
        st <= S_CTRL; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
        wr_commit <= wrote;
        wrote <= 1'b0;
      end else if (scl_rise) begin
        if (bitcnt < 4'd8) sr <= {sr[6:0], sda_s};
        if (bitcnt == 4'd8) mack <= ~sda_s;
        if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && st != S_IDLE) begin
        if (bitcnt == 4'd8) begin
          if (st == S_READ) sda_oe <= 1'b0;
          else if (busy || (st == S_CTRL && !match)) begin
            st <= S_IDLE; sda_oe <= 1'b0;
          end else begin
            sda_oe <= 1'b1;
            case (st)
              S_CTRL:  if (!sr[0]) blk <= sr[3 -: BLK_W];
              S_ADDR:  ptr <= {blk, sr};
              S_WRITE: begin
                wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sr; wrote <= 1'b1;
                ptr <= (ptr & ~PMASK) | ((ptr + 1'b1) & PMASK);
              end
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (st)
            S_CTRL: if (sr[0]) begin
              st <= S_READ; tx <= rd_data; ptr <= ptr + 1'b1; sda_oe <= ~rd_data[7];
            end else st <= S_ADDR;
            S_ADDR: st <= S_WRITE;
            S_READ: if (mack) begin
              tx <= rd_data; ptr <= ptr + 1'b1; sda_oe <= ~rd_data[7];
            end else st <= S_IDLE;
            default: ;
          endcase
        end else if (st == S_READ && bitcnt != 4'd0) begin
          sda_oe <= ~tx[6];
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && bitcnt == 4'd8 && busy && st != S_READ) |=> !sda_oe);
  a_r3_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(busy));
  a_r1_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bitcnt == 4'd0 && st == S_CTRL));
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b010;
  logic sda_oe, wr_en, wr_commit;
  logic [10:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  logic [7:0] mem [2048];
  logic [10:0] wa [1024];
  logic [7:0]  wd [1024];
  int wn = 0, cb = 0, cn = 0;
  int vecs = 0, bad = 0;
  bit done = 0;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 29 + (a >> 5) * 3 + 17);
  endfunction
  function automatic logic [7:0] ctl(logic [3:0] hi, logic [2:0] b, logic rw);
    return {hi, b, rw};
  endfunction
  function automatic logic [10:0] pinc(logic [10:0] a);
    return {a[10:4], a[3:0] + 4'd1};
  endfunction

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  always @(negedge clk) begin
    if (wr_en && wn < 1024) begin wa[wn] = wr_addr; wd[wn] = wr_data; wn++; end
    if (wr_commit) begin
      for (int k = cb; k < wn; k++) mem[wa[k]] = wd[k];
      cb = wn; cn++;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic st();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask
  task automatic sp();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask
  task automatic pbits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    end
  endtask
  task automatic wbyte(input logic [7:0] b, output bit ack);
    pbits(b, 8);
    sda_m = 1; q(); scl_m = 1; q(); ack = ~sda_line; q(); scl_m = 0; q();
  endtask
  task automatic rbyte(output logic [7:0] b, input bit mack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1; q(); b[i] = sda_line; q(); scl_m = 0;
    end
    q(); sda_m = ~mack; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
  endtask

  task automatic set_ptr(input logic [10:0] a, input string req);
    bit k;
    st(); wbyte(ctl(4'b1000, a[10:8], 1'b0), k); chk(k, 1, req);
    wbyte(a[7:0], k); chk(k, 1, req);
  endtask

  task automatic seq_read(input logic [10:0] a, input int n, input string req);
    bit k; logic [7:0] b;
    st(); wbyte(ctl(4'b1000, 3'd0, 1'b1), k); chk(k, 1, req);
    for (int i = 0; i < n; i++) begin
      rbyte(b, i != n - 1);
      chk(b, mem[11'(a + i)], req);
    end
    sp();
  endtask

  initial begin
    bit k; logic [7:0] b; int w0, c0; logic [10:0] a, e; int n; int unsigned s;
    for (int i = 0; i < 2048; i++) mem[i] = pat(i);
    s = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    chk(sda_oe, 0, "R11 reset oe"); chk(wr_en, 0, "R11 reset wr_en");
    chk(wr_commit, 0, "R11 reset commit");
    rst_n = 1; q();

    // R2 mismatch: A1 not inverted
    st(); wbyte(ctl(4'b1010, 3'd0, 1'b0), k); chk(k, 0, "R2 mismatch nack");
    wbyte(8'h00, k); chk(k, 0, "R2 silent after mismatch"); sp();

    // R4 R5 R6 byte write
    w0 = wn; c0 = cn;
    set_ptr(11'h53C, "R4 addr ack"); wbyte(8'hA5, k); chk(k, 1, "R5 data ack"); sp();
    chk(wn - w0, 1, "R5 one strobe"); chk(wa[w0], 11'h53C, "R4 write address");
    chk(wd[w0], 8'hA5, "R5 write data"); chk(cn - c0, 1, "R6 commit after data");

    // R5 page wrap
    w0 = wn; set_ptr(11'h53E, "R5 page addr");
    for (int i = 0; i < 4; i++) begin wbyte(8'(8'h10 + i), k); chk(k, 1, "R5 page ack"); end
    sp();
    e = 11'h53E;
    for (int i = 0; i < 4; i++) begin chk(wa[w0 + i], e, "R5 page wrap addr"); e = pinc(e); end
    // R8 current read after write: pointer is 0x532
    seq_read(11'h532, 1, "R8 after write");
    seq_read(11'h533, 1, "R8 after read");

    // R7 random read, R6 no commit
    c0 = cn; set_ptr(11'h53C, "R7 set"); seq_read(11'h53C, 1, "R7 random read A5");
    chk(cn - c0, 0, "R6 no commit without data");
    set_ptr(11'h210, "R7 set"); seq_read(11'h210, 4, "R9 sequential");
    seq_read(11'h214, 1, "R8 current address");

    // R9 top wrap
    set_ptr(11'h7FE, "R9 set"); seq_read(11'h7FE, 3, "R9 wrap 7FF to 000");

    // R3 busy
    busy = 1; st(); wbyte(ctl(4'b1000, 3'd1, 1'b0), k); chk(k, 0, "R3 ctrl nack busy"); sp();
    busy = 0; w0 = wn; c0 = cn;
    set_ptr(11'h100, "R3 set"); busy = 1; wbyte(8'h77, k); chk(k, 0, "R3 data nack busy"); sp();
    chk(wn - w0, 0, "R3 no write busy"); chk(cn - c0, 0, "R3 no commit busy"); busy = 0;
    st(); wbyte(ctl(4'b1000, 3'd1, 1'b0), k); chk(k, 1, "R3 ack after busy"); sp();

    // R1 START mid-byte
    st(); pbits(8'hFF, 4); st(); wbyte(ctl(4'b1000, 3'd0, 1'b0), k); chk(k, 1, "R1 restart mid byte"); sp();

    // R10 release after NACK
    set_ptr(11'h020, "R10 set");
    st(); wbyte(ctl(4'b1000, 3'd0, 1'b1), k); rbyte(b, 0); chk(b, mem[11'h020], "R10 data");
    n = 0;
    for (int i = 0; i < 9; i++) begin
      q(); scl_m = 1; q(); if (!sda_line) n++; q(); scl_m = 0; q();
    end
    chk(n, 0, "R10 released after nack"); sp();

    // random write/readback
    for (int it = 0; it < 14; it++) begin
      a = 11'($urandom); n = 1 + int'($urandom % 5); w0 = wn;
      set_ptr(a, "R4 rand set");
      for (int i = 0; i < n; i++) begin wbyte(8'($urandom), k); chk(k, 1, "R5 rand ack"); end
      sp();
      e = a;
      for (int i = 0; i < n; i++) begin chk(wa[w0 + i], e, "R5 rand addr"); e = pinc(e); end
      set_ptr(a, "R7 rand set"); seq_read(a, n, "R9 rand readback");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule